// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. It takes one request at a time: program a single byte, erase one 64 KiB sector, or erase the whole device. It turns the request into the fixed series of unlock and command bus writes that the flash expects, and it shapes every write-enable pulse from a cycle count set by a parameter. After the last write it reads the target location again and again. It watches bit 7 of each read: while the flash's internal algorithm runs, that bit comes back as the complement of the final value.

The operation ends in one of two ways. It ends with a one-cycle `done` pulse when bit 7 matches the expected value. It ends with a one-cycle `error` pulse when the number of busy reads reaches the limit the host gave with the request. `busy` stays high for the whole operation, and a request that arrives while the block is busy has no effect.

Top module: `flash_cmd_seq`

## Requirements
- R1: Request code 0 (byte program) produces exactly four bus writes, in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R2: Request codes 1 and 2 (erase) produce exactly six bus writes. The first five are, in order: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh.
- R3: The sixth erase write depends on the code. For code 2 (chip erase) it is 10h at 5555h. For code 1 (sector erase) it is 30h at the sector base: the top 3 bits of the 19-bit request address, followed by sixteen zero bits.
- R4: Write enable stays low for exactly WE_LO_CYC cycles and stays high for at least WE_HI_CYC cycles between writes. Address and write data are valid one cycle before write enable falls and do not change while it is low.
- R5: After the last write the block polls with output enable low and write enable high for RD_CYC cycles per read. It reads the request address for code 0, the sector base for code 1 and address 0 for code 2. Polling ends with a one-cycle `done` pulse at the first read whose bit 7 equals the expected value: data bit 7 for a program, 1 for an erase.
- R6: A read whose bit 7 does not match is a busy read. When the count of busy reads reaches `poll_limit` (a limit of 0 acts as 1), the operation ends with a one-cycle `error` pulse and no `done` pulse.
- R7: `busy` rises in the cycle after the block accepts a request. It stays high, with chip enable low, until the cycle in which `done` or `error` pulses, and it is low in that cycle.
- R8: A request that arrives while `busy` is high is ignored. Request code 3 is reserved and is ignored. Neither one produces a bus write.
- R9: After reset `busy`, `done` and `error` are low and chip enable, write enable and output enable are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | 19 | Target byte address |
| req_data | input | 8 | Byte to program |
| poll_limit | input | 32 | Busy reads allowed before error |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle timeout pulse |
| fl_addr | output | 19 | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest case to reach from the ports is the timeout path: a flash that stays busy long enough for the busy-read counter to reach its limit. A second hard case is a limit of zero, which must stop the operation at the very first read. The bench models the flash with a counter of reads that still return the complemented bit 7. A large count keeps the part busy past any small limit, so both the normal end and the timeout end happen within a few hundred cycles. A new request is also injected part-way through a chip erase, to show that the script is not disturbed.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int FL_AW     = 19;
    localparam int FL_DW     = 8;
    localparam int SECT_BITS = 3;

    localparam logic [FL_AW-1:0] UNLK_A = 19'h05555;
    localparam logic [FL_AW-1:0] UNLK_B = 19'h02AAA;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } fop_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSET,
        S_WLOW,
        S_WHIGH,
        S_PREAD,
        S_PGAP
    } fst_t;

    typedef struct packed {
        logic [FL_AW-1:0] addr;
        logic [FL_DW-1:0] data;
    } bus_wr_t;

    function automatic logic [FL_AW-1:0] sector_base(input logic [FL_AW-1:0] a);
        return {a[FL_AW-1 -: SECT_BITS], {(FL_AW-SECT_BITS){1'b0}}};
    endfunction

    function automatic logic [2:0] script_len(input fop_t op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

    function automatic logic [FL_AW-1:0] poll_target(input fop_t op,
                                                     input logic [FL_AW-1:0] a);
        case (op)
            OP_PROG: return a;
            OP_SECT: return sector_base(a);
            default: return '0;
        endcase
    endfunction

    function automatic bus_wr_t script_entry(input fop_t op,
                                             input logic [2:0] step,
                                             input logic [FL_AW-1:0] a,
                                             input logic [FL_DW-1:0] d);
        bus_wr_t w;
        w = '{addr: UNLK_A, data: 8'hAA};
        case (step)
            3'd0: w = '{addr: UNLK_A, data: 8'hAA};
            3'd1: w = '{addr: UNLK_B, data: 8'h55};
            3'd2: w = '{addr: UNLK_A, data: (op == OP_PROG) ? 8'hA0 : 8'h80};
            3'd3: w = (op == OP_PROG) ? '{addr: a, data: d}
                                      : '{addr: UNLK_A, data: 8'hAA};
            3'd4: w = '{addr: UNLK_B, data: 8'h55};
            3'd5: w = (op == OP_CHIP) ? '{addr: UNLK_A, data: 8'h10}
                                      : '{addr: sector_base(a), data: 8'h30};
            default: w = '{addr: UNLK_A, data: 8'hAA};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fseq_script.sv
module fseq_script
    import fseq_pkg::*;
(
    input  fop_t              op,
    input  logic [2:0]        step,
    input  logic [FL_AW-1:0]  addr,
    input  logic [FL_DW-1:0]  data,
    output bus_wr_t           wr,
    output logic              last
);
    always_comb begin
        wr   = script_entry(op, step, addr, data);
        last = (step == script_len(op) - 3'd1);
    end
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fseq_poll.sv
module fseq_poll #(
    parameter int TO_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sample,
    input  logic            rd_bit7,
    input  logic            exp_bit7,
    input  logic [TO_W-1:0] limit,
    output logic            ok,
    output logic            tmo
);
    logic [TO_W-1:0] busy_reads;
    logic [TO_W:0]   next_cnt;

    assign ok       = (rd_bit7 == exp_bit7);
    assign next_cnt = {1'b0, busy_reads} + 1'b1;
    assign tmo      = !ok && (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || start)        busy_reads <= '0;
        else if (sample && !ok)  busy_reads <= next_cnt[TO_W-1:0];
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int WE_LO_CYC = 3,
    parameter int WE_HI_CYC = 2,
    parameter int RD_CYC    = 4,
    parameter int TO_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [FL_AW-1:0]  req_addr,
    input  logic [FL_DW-1:0]  req_data,
    input  logic [TO_W-1:0]   poll_limit,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [FL_AW-1:0]  fl_addr,
    output logic [FL_DW-1:0]  fl_wdata,
    input  logic [FL_DW-1:0]  fl_rdata,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int TMAX_A = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
    localparam int TMAX   = (TMAX_A > RD_CYC) ? TMAX_A : RD_CYC;
    localparam int TW     = (TMAX > 1) ? $clog2(TMAX) : 1;

    fst_t             st, st_n;
    fop_t             op_q;
    logic [2:0]       step;
    logic [FL_AW-1:0] addr_q;
    logic [FL_DW-1:0] data_q;
    logic [TO_W-1:0]  lim_q;

    logic             accept, sample, t_load, t_zero, last, p_ok, p_tmo;
    logic [TW-1:0]    t_val;
    bus_wr_t          wr;

    fseq_script u_script (
        .op   (op_q),
        .step (step),
        .addr (addr_q),
        .data (data_q),
        .wr   (wr),
        .last (last)
    );

    fseq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    fseq_poll #(.TO_W(TO_W)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .sample   (sample),
        .rd_bit7  (fl_rdata[FL_DW-1]),
        .exp_bit7 ((op_q == OP_PROG) ? data_q[FL_DW-1] : 1'b1),
        .limit    (lim_q),
        .ok       (p_ok),
        .tmo      (p_tmo)
    );

    always_comb begin
        st_n   = st;
        accept = 1'b0;
        sample = 1'b0;
        t_load = 1'b0;
        t_val  = '0;
        case (st)
            S_IDLE: begin
                if (req_valid && fop_t'(req_op) != OP_RSVD) begin
                    accept = 1'b1;
                    st_n   = S_WSET;
                end
            end
            S_WSET: begin
                st_n   = S_WLOW;
                t_load = 1'b1;
                t_val  = TW'(WE_LO_CYC - 1);
            end
            S_WLOW: begin
                if (t_zero) begin
                    st_n   = S_WHIGH;
                    t_load = 1'b1;
                    t_val  = TW'(WE_HI_CYC - 1);
                end
            end
            S_WHIGH: begin
                if (t_zero) begin
                    if (last) begin
                        st_n   = S_PREAD;
                        t_load = 1'b1;
                        t_val  = TW'(RD_CYC - 1);
                    end else begin
                        st_n = S_WSET;
                    end
                end
            end
            S_PREAD: begin
                if (t_zero) begin
                    sample = 1'b1;
                    st_n   = (p_ok || p_tmo) ? S_IDLE : S_PGAP;
                end
            end
            S_PGAP: begin
                st_n   = S_PREAD;
                t_load = 1'b1;
                t_val  = TW'(RD_CYC - 1);
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            op_q   <= OP_PROG;
            step   <= '0;
            addr_q <= '0;
            data_q <= '0;
            lim_q  <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
        end else begin
            st    <= st_n;
            done  <= sample && p_ok;
            error <= sample && !p_ok && p_tmo;
            if (accept) begin
                op_q   <= fop_t'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                lim_q  <= poll_limit;
                step   <= '0;
            end else if (st == S_WHIGH && t_zero && !last) begin
                step <= step + 3'd1;
            end
        end
    end

    always_comb begin
        busy     = (st != S_IDLE);
        fl_ce_n  = !busy;
        fl_we_n  = (st != S_WLOW);
        fl_oe_n  = (st != S_PREAD);
        fl_addr  = '0;
        fl_wdata = '0;
        if (st == S_WSET || st == S_WLOW || st == S_WHIGH) begin
            fl_addr  = wr.addr;
            fl_wdata = wr.data;
        end else if (st == S_PREAD || st == S_PGAP) begin
            fl_addr  = poll_target(op_q, addr_q);
        end
    end
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker
    import fseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic [FL_AW-1:0] fl_addr,
    input logic [FL_DW-1:0] fl_wdata,
    input logic             fl_ce_n,
    input logic             fl_we_n,
    input logic             fl_oe_n
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fl_ce_n && fl_we_n && fl_oe_n));

    p_we_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> ($stable(fl_addr) && $stable(fl_wdata)));

    p_no_rd_wr_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));

    p_end_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || error));

    p_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy);

    p_ce_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !fl_ce_n);
endmodule

bind flash_cmd_seq fseq_checker u_fseq_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    localparam int CLK_NS = 20;
    localparam int WE_LO  = 3;
    localparam int WE_HI  = 2;

    typedef struct {
        logic [18:0] a;
        logic [7:0]  d;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_bad = 0, cyc_total = 0;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [31:0] poll_limit = '0;
    logic        busy, done, error, fl_ce_n, fl_we_n, fl_oe_n;
    logic [18:0] fl_addr;
    logic [7:0]  fl_wdata, fl_rdata;

    int          busy_left = 0;
    logic        exp_b7 = 1'b1;
    logic [18:0] exp_poll = '0;
    int          reads = 0, writes = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .poll_limit(poll_limit),
        .busy(busy), .done(done), .error(error), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    // flash model: complemented bit 7 while reads remain busy
    assign fl_rdata = (busy_left > 0) ? {~exp_b7, 7'h55} : {exp_b7, 7'h2A};

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc_total);
            summary();
        end
    end

    // bus monitor and scoreboard consumer
    logic        prev_we = 1'b1, prev_oe = 1'b1;
    int          lo_run = 0, hi_run = 1000;
    logic [18:0] la;
    logic [7:0]  ld;
    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_we_n) begin
                if (prev_we)
                    check(hi_run >= WE_HI, "R4", "write enable high time", hi_run, WE_HI);
                lo_run++;
                la = fl_addr;
                ld = fl_wdata;
            end else begin
                if (!prev_we) begin
                    writes++;
                    check(lo_run == WE_LO, "R4", "write enable low width", lo_run, WE_LO);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected write", la, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(la == e.a, e.rq, "write address", la, e.a);
                        check(ld == e.d, e.rq, "write data", ld, e.d);
                    end
                    lo_run = 0;
                    hi_run = 0;
                end
                hi_run++;
            end
            if (!fl_oe_n && prev_oe) begin
                check(fl_addr == exp_poll, "R5", "poll address", fl_addr, exp_poll);
                check(fl_we_n == 1'b1, "R5", "write enable during read", fl_we_n, 1);
            end
            if (!prev_oe && fl_oe_n) begin
                reads++;
                if (busy_left > 0) busy_left--;
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    task automatic push(input logic [18:0] a, input logic [7:0] d, input string rq);
        exp_t e;
        e.a = a; e.d = d; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [18:0] addr,
                          input logic [7:0] data, input int lim, input int busy_n,
                          input bit exp_err, input logic [18:0] paddr, input bit inject);
        int  exp_reads;
        int  cyc;
        string rq;
        rq = (op == 2'd0) ? "R1" : "R2";
        push(19'h05555, 8'hAA, rq);
        push(19'h02AAA, 8'h55, rq);
        if (op == 2'd0) begin
            push(19'h05555, 8'hA0, "R1");
            push(addr, data, "R1");
            exp_b7 = data[7];
        end else begin
            push(19'h05555, 8'h80, "R2");
            push(19'h05555, 8'hAA, "R2");
            push(19'h02AAA, 8'h55, "R2");
            if (op == 2'd2) push(19'h05555, 8'h10, "R3");
            else            push({addr[18:16], 16'h0000}, 8'h30, "R3");
            exp_b7 = 1'b1;
        end
        busy_left = busy_n;
        exp_poll  = paddr;
        reads     = 0;
        exp_reads = exp_err ? ((lim == 0) ? 1 : lim) : busy_n + 1;

        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = addr;
        req_data   = data;
        poll_limit = lim;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R7", "busy after accept", busy, 1);
        cyc = 0;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            // R8: a request while busy must not disturb the script
            if (inject && cyc == 5) begin
                req_valid = 1'b1; req_op = 2'd0; req_addr = 19'h00001; req_data = 8'h00;
            end else begin
                req_valid = 1'b0;
            end
            if (done || error) break;
        end
        req_valid = 1'b0;
        check(done == !exp_err, exp_err ? "R6" : "R5", "done flag", done, !exp_err);
        check(error == exp_err, "R6", "error flag", error, exp_err);
        check(busy == 1'b0, "R7", "busy at end pulse", busy, 0);
        @(negedge clk);
        check(!done && !error, "R5", "end pulse one cycle", {done, error}, 0);
        check(exp_q.size() == 0, rq, "writes left undone", exp_q.size(), 0);
        check(reads == exp_reads, exp_err ? "R6" : "R5", "poll reads", reads, exp_reads);
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(busy == 0 && done == 0 && error == 0, "R9", "status after reset",
              {busy, done, error}, 0);
        check(fl_ce_n && fl_we_n && fl_oe_n, "R9", "strobes after reset",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);

        // R1/R5: program, bit 7 of data is 0, three busy reads
        run_op(2'd0, 19'h12345, 8'h3C, 100, 3, 1'b0, 19'h12345, 1'b0);
        // R1/R5: program, bit 7 is 1, ready at first read
        run_op(2'd0, 19'h7FFFF, 8'hA5, 100, 0, 1'b0, 19'h7FFFF, 1'b0);
        // R2/R3: sector erase, sector 5
        run_op(2'd1, 19'h5ABCD, 8'h00, 100, 2, 1'b0, 19'h50000, 1'b0);
        // R2/R3/R8: chip erase with a request injected while busy
        run_op(2'd2, 19'h3C3C3, 8'h00, 100, 4, 1'b0, 19'h00000, 1'b1);
        // R6: program that never finishes, limit 3
        run_op(2'd0, 19'h00100, 8'h80, 3, 1000, 1'b1, 19'h00100, 1'b0);
        // R6: sector erase with limit 0 acts as 1
        run_op(2'd1, 19'h0FFFF, 8'h00, 0, 1000, 1'b1, 19'h00000, 1'b0);

        // R8: reserved code 3 is ignored
        writes = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 19'h01234; req_data = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(busy == 1'b0, "R8", "busy after reserved code", busy, 0);
        check(writes == 0, "R8", "writes after reserved code", writes, 0);
        summary();
    end
endmodule